// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Row Driver

This block is the logic core of a display row driver. A serial bit stream is clocked into a chain of storage stages, one per output channel. A direction input picks which end of the chain receives new data. The stage at the opposite end is presented on a serial output, so several drivers can be chained.

Every channel has a three-state output, modelled as a drive enable and a drive level. A stored one drives the row to the level chosen by the polarity input. A stored zero leaves the row floating. A low enable floats every row. Enable and polarity act directly on the outputs and never alter the stored pattern.

Top module: `row_shift_driver`

## Requirements
- R1: There are NCH channels (default 34), and channel k (bit k of each output bus) is controlled only by storage stage k. A single stored one drives exactly one channel.
- R2: The chain samples `ser_in` and shifts only on the falling edge of `clk`. Between falling edges, including at rising edges, its contents do not change.
- R3: With `dir` low, each stage k takes the old value of stage k-1, `ser_in` enters stage 0, and `ser_out` shows stage NCH-1.
- R4: With `dir` high, each stage k takes the old value of stage k+1, `ser_in` enters stage NCH-1, and `ser_out` shows stage 0.
- R5: With `out_en` low, every channel floats (`drv_en` all 0), whatever the stored data or polarity.
- R6: With `out_en` high, a channel whose stage holds 1 is driven (`drv_en`=1), and `drv_val` equals `pol` (1 = high, 0 = low).
- R7: With `out_en` high, a channel whose stage holds 0 floats for either polarity.
- R8: `ser_out` depends only on the stored data and `dir`. `out_en` and `pol` do not affect it.
- R9: `drv_val` is 0 on every channel whose `drv_en` is 0.
- R10: Asserting `rst_n` low clears every stage at once, without a clock, so all channels float afterwards even with `out_en` high.
- R11: Changing `out_en` or `pol` updates the outputs without a clock edge and leaves the stored data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the falling edge is active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir | input | 1 | Shift direction: 0 shifts toward higher stages, 1 toward lower |
| ser_in | input | 1 | Serial data input |
| out_en | input | 1 | Output enable: 0 floats every channel |
| pol | input | 1 | Level driven by a stored one: 1 high, 0 low |
| ser_out | output | 1 | Cascade output taken from the far-end stage |
| drv_en | output | NCH | Per-channel drive enable |
| drv_val | output | NCH | Per-channel drive level, 0 when not driven |

## Verification
The shift properties assume that `dir` and `ser_in` are steady around each falling edge. They also assume that reset is released away from a falling edge. The stimulus changes every input only just after a rising edge, half a period from the shifting edge. Enable and polarity are also toggled in the middle of a clock phase, to show that the outputs follow them at once while the stored data does not change.

// File: rtl/row_shift_driver.sv
module row_shift_driver #(
  parameter int NCH = 34
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir,
  input  logic           ser_in,
  input  logic           out_en,
  input  logic           pol,
  output logic           ser_out,
  output logic [NCH-1:0] drv_en,
  output logic [NCH-1:0] drv_val
);

  logic [NCH-1:0] sr;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)   sr <= '0;
    else if (dir) sr <= {ser_in, sr[NCH-1:1]};
    else          sr <= {sr[NCH-2:0], ser_in};
  end

  assign ser_out = dir ? sr[0] : sr[NCH-1];
  assign drv_en  = out_en ? sr : '0;
  assign drv_val = (out_en && pol) ? sr : '0;

endmodule

module row_shift_driver_chk #(
  parameter int NCH = 34
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dir,
  input logic           ser_in,
  input logic           out_en,
  input logic           pol,
  input logic           ser_out,
  input logic [NCH-1:0] drv_en,
  input logic [NCH-1:0] drv_val,
  input logic [NCH-1:0] q
);

  p_shift_up_r3: assert property (@(negedge clk) disable iff (!rst_n)
    !dir |=> (q[0] == $past(ser_in)) && (q[NCH-1:1] == $past(q[NCH-2:0])));

  p_shift_down_r4: assert property (@(negedge clk) disable iff (!rst_n)
    dir |=> (q[NCH-1] == $past(ser_in)) && (q[NCH-2:0] == $past(q[NCH-1:1])));

  p_all_float_r5: assert property (@(negedge clk) disable iff (!rst_n)
    !out_en |-> (drv_en == '0));

  p_level_high_r6: assert property (@(negedge clk) disable iff (!rst_n)
    (out_en && pol) |-> (drv_val == drv_en));

  p_level_low_r6: assert property (@(negedge clk) disable iff (!rst_n)
    (out_en && !pol) |-> (drv_val == '0));

  p_cascade_r8: assert property (@(negedge clk) disable iff (!rst_n)
    ($stable(q) && $stable(dir)) |-> $stable(ser_out));

  p_idle_val_r9: assert property (@(negedge clk) disable iff (!rst_n)
    (drv_val & ~drv_en) == '0);

endmodule

bind row_shift_driver row_shift_driver_chk #(.NCH(NCH)) i_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .ser_in(ser_in), .out_en(out_en),
  .pol(pol), .ser_out(ser_out), .drv_en(drv_en), .drv_val(drv_val), .q(sr)
);

// File: tb/test_row_shift_driver.sv
module test_row_shift_driver;
  localparam int NCH = 34;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir = 1'b0, ser_in = 1'b0, out_en = 1'b1, pol = 1'b1;
  logic ser_out;
  logic [NCH-1:0] drv_en, drv_val;

  int compared = 0, mismatched = 0;
  string tag = "R10";
  bit m [NCH];

  row_shift_driver #(.NCH(NCH)) i_row_shift_driver (
    .clk(clk), .rst_n(rst_n), .dir(dir), .ser_in(ser_in), .out_en(out_en),
    .pol(pol), .ser_out(ser_out), .drv_en(drv_en), .drv_val(drv_val)
  );

  always #10 clk = ~clk;

  // reference model: stage list updated on each falling edge
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) m[i] = 1'b0;
    end else if (!dir) begin
      for (int i = NCH-1; i > 0; i--) m[i] = m[i-1];
      m[0] = ser_in;
    end else begin
      for (int i = 0; i < NCH-1; i++) m[i] = m[i+1];
      m[NCH-1] = ser_in;
    end
  end

  task automatic check_now(string t);
    logic [NCH-1:0] e_en, e_val;
    logic e_so;
    for (int i = 0; i < NCH; i++) begin
      e_en[i]  = out_en & m[i];
      e_val[i] = out_en & pol & m[i];
    end
    e_so = dir ? m[0] : m[NCH-1];
    compared++;
    if (drv_en !== e_en || drv_val !== e_val || ser_out !== e_so) begin
      mismatched++;
      $display("FAIL %s: en=%h val=%h so=%b expected en=%h val=%h so=%b",
               t, drv_en, drv_val, ser_out, e_en, e_val, e_so);
    end
  endtask

  always @(posedge clk) begin
    #1 check_now(tag);
  end

  task automatic step(input logic d, input logic s, input logic o, input logic p);
    @(posedge clk); #2;
    dir = d; ser_in = s; out_en = o; pol = p;
  endtask

  initial begin
    // R10: reset state, enable high, all rows float
    #5 check_now("R10");
    step(0, 1, 1, 1);
    rst_n = 1'b1;
    // R1: single one walks up, one channel at a time (R3 dir low)
    tag = "R1";
    step(0, 1, 1, 1);
    for (int i = 0; i < NCH + 2; i++) step(0, 0, 1, 1);
    // R3: pattern shifted up, R2 checked at every rising edge
    tag = "R3";
    for (int i = 0; i < 50; i++) step(0, i[0] ^ i[2], 1, i[3]);
    // R4: shift down, cascade from stage 0
    tag = "R4";
    for (int i = 0; i < 50; i++) step(1, i[1] | i[4], 1, i[0]);
    // R5: enable low, everything floats
    tag = "R5";
    for (int i = 0; i < 20; i++) step(i[0], 1, 0, i[1]);
    // R6 / R7: stored ones drive per polarity, zeros float
    tag = "R6";
    for (int i = 0; i < 20; i++) step(0, i[0], 1, 1);
    tag = "R7";
    for (int i = 0; i < 20; i++) step(0, i[1], 1, 0);
    // R8: enable and polarity toggled while ser_out tracked
    tag = "R8";
    for (int i = 0; i < 40; i++) step(i[5], $urandom_range(0, 1), i[0], i[1]);
    // R9: low polarity so idle level checked everywhere
    tag = "R9";
    for (int i = 0; i < 20; i++) step(1, i[2], i[0], 0);
    // R11: combinational enable/polarity changes between edges
    tag = "R11";
    step(0, 1, 1, 1);
    step(0, 1, 1, 1);
    #1 out_en = 1'b0; #1 check_now("R11");
    #1 out_en = 1'b1; #1 check_now("R11");
    #1 pol = 1'b0;    #1 check_now("R11");
    #1 pol = 1'b1;    #1 check_now("R11");
    step(0, 0, 1, 1);
    // R10: asynchronous reset mid-cycle
    tag = "R10";
    @(posedge clk); #3 rst_n = 1'b0; #1 check_now("R10");
    step(0, 1, 1, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1);
    @(posedge clk); #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule